// File: doc/BRIEF.md
# CAN Bus Integration Gate

This block decides when a CAN controller may take part in bus traffic after a reset. After reset it stays idle and keeps the transmit driver off. It starts to watch the bus only once software sets at least one of the controller's transmit-enable bits. From then on it counts consecutive recessive bits, one per pulse of the bit-sample strobe from the bit-timing logic. Once an unbroken run of eleven has been seen, it opens the gate. The open gate lets the transmit data reach the bus pin and passes sample strobes on to the frame decoder. The gate is shut until then, so the node never starts driving into a message that is already on the wire.

The block also holds the reset image of the fault-confinement state. That state is the confinement mode (error-active after reset), the transmit and receive error counters (zero), and the controller status word. In the status word every bit is zero except the transmit-buffer-empty flag, which is one. Updating these values after reset belongs to other logic.

Top module: `can_integ_gate`

## Requirements
- R1: While `rst` is high and on the first cycle after it: `bus_ready`=0, `drv_oe`=0, `tx_line`=1, `rx_accept`=0, `err_mode`=2'b00 (error-active), `tx_err_cnt`=0, `rx_err_cnt`=0, and `status_word`=8'h04. In that status value only bit 2, the transmit-buffer-empty flag, is set.
- R2: While both bits of `xmit_enable` are 0, recessive strobes are not counted and `bus_ready` stays 0.
- R3: Counting starts on the cycle after an enable bit is first seen. `bus_ready` rises at the clock edge that samples the eleventh consecutive recessive strobe (`sample_stb`=1, `rx_bit`=1). After only ten such strobes it is still 0.
- R4: A dominant strobe (`rx_bit`=0) before the gate opens restarts the run. Eleven further recessive strobes are then needed.
- R5: Either enable bit on its own (bit 0 or bit 1) is enough to start integration.
- R6: When both enable bits are cleared, `bus_ready` falls at the next edge. A later re-enable needs a full new run of eleven.
- R7: Only cycles with `sample_stb`=1 count. A recessive `rx_bit` without a strobe does not advance the run, and a dominant `rx_bit` without a strobe does not break it.
- R8: `drv_oe` follows `bus_ready`. `tx_line` equals `tx_data` while `bus_ready` is 1 and is held recessive (1) otherwise.
- R9: `rx_accept` equals `sample_stb` while `bus_ready` is 1 and is 0 otherwise.
- R10: Once the gate is open, dominant strobes (frame traffic) do not close it.
- R11: `err_mode`, the error counters and `status_word` keep their reset values through all integration activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xmit_enable | input | EN_W (2) | Software transmit-enable bits |
| sample_stb | input | 1 | One-cycle pulse at each bit-sample point |
| rx_bit | input | 1 | Sampled bus level, 1 = recessive |
| tx_data | input | 1 | Transmit bit from the frame encoder |
| bus_ready | output | 1 | Integration complete, bus participation allowed |
| drv_oe | output | 1 | Transmit driver enable |
| tx_line | output | 1 | Gated transmit level toward the pin |
| rx_accept | output | 1 | Sample strobe forwarded to the frame decoder |
| err_mode | output | 2 | Confinement mode, 00 = error-active |
| tx_err_cnt | output | ERR_W (8) | Transmit error counter |
| rx_err_cnt | output | ERR_W (8) | Receive error counter |
| status_word | output | STAT_W (8) | Controller status, buffer-empty flag at bit TBE_POS |

## Verification
The assertions assume that `sample_stb` is a pulse that is sampled at a clock edge, and that `rx_bit` carries meaning only on cycles where that strobe is high. They also assume `xmit_enable` changes only between clock edges. The bench drives every input on the falling edge and holds each strobe for exactly one rising edge. Between strobes it leaves `rx_bit` at various levels, so the claim that non-strobe cycles are ignored is tested against those levels rather than taken for granted.

// File: rtl/can_integ_pkg.sv
package can_integ_pkg;

  typedef enum logic [1:0] {
    GATE_OFF   = 2'd0,
    GATE_COUNT = 2'd1,
    GATE_OPEN  = 2'd2
  } gate_state_t;

  typedef enum logic [1:0] {
    CONF_ACTIVE  = 2'd0,
    CONF_PASSIVE = 2'd1,
    CONF_BUSOFF  = 2'd2
  } conf_mode_t;

endpackage

// File: rtl/can_integ_enable_track.sv
module can_integ_enable_track #(
  parameter int EN_W = 2
) (
  input  logic [EN_W-1:0] en_bits,
  output logic            any_en
);

  logic [EN_W:0] chain;

  assign chain[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < EN_W; gi++) begin : g_or
      assign chain[gi+1] = chain[gi] | en_bits[gi];
    end
  endgenerate

  assign any_en = chain[EN_W];

endmodule

// File: rtl/can_integ_run_counter.sv
module can_integ_run_counter #(
  parameter int LIMIT = 11,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  output logic [CW-1:0] count,
  output logic          hit
);

  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  assign hit = step && !clear && (count == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear || hit) begin
      count <= '0;
    end else if (step) begin
      count <= count + 1'b1;
    end
  end

  // R3
  step_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !clear && !hit) |=> (count == $past(count) + 1'b1));

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (count == '0));

endmodule

// File: rtl/can_integ_fsm.sv
module can_integ_fsm
  import can_integ_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic any_en,
  input  logic strobe,
  input  logic rx_bit,
  input  logic run_hit,
  output logic ctr_clear,
  output logic ctr_step,
  output logic ready_q
);

  gate_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GATE_OFF:   if (any_en) state_d = GATE_COUNT;
      GATE_COUNT: begin
        if (!any_en)      state_d = GATE_OFF;
        else if (run_hit) state_d = GATE_OPEN;
      end
      GATE_OPEN:  if (!any_en) state_d = GATE_OFF;
      default:    state_d = GATE_OFF;
    endcase
  end

  assign ctr_step  = (state_q == GATE_COUNT) && any_en && strobe && rx_bit;
  assign ctr_clear = (state_q != GATE_COUNT) || !any_en || (strobe && !rx_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= GATE_OFF;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= (state_d == GATE_OPEN);
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !any_en |=> !ready_q);

  // R10
  open_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_q && any_en) |=> ready_q);

endmodule

// File: rtl/can_integ_reset_image.sv
module can_integ_reset_image
  import can_integ_pkg::*;
#(
  parameter int ERR_W   = 8,
  parameter int STAT_W  = 8,
  parameter int TBE_POS = 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic [1:0]        mode_q,
  output logic [ERR_W-1:0]  tec_q,
  output logic [ERR_W-1:0]  rec_q,
  output logic [STAT_W-1:0] stat_q
);

  localparam logic [STAT_W-1:0] STAT_INIT = STAT_W'(1) << TBE_POS;

  logic seen_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= CONF_ACTIVE;
      tec_q    <= '0;
      rec_q    <= '0;
      stat_q   <= STAT_INIT;
      seen_rst <= 1'b1;
    end else begin
      seen_rst <= seen_rst;
    end
  end

  // R11
  image_stable_chk: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    $past(seen_rst) |-> ($stable(tec_q) && $stable(rec_q) && $stable(stat_q)));

endmodule

// File: rtl/can_integ_gate.sv
module can_integ_gate
  import can_integ_pkg::*;
#(
  parameter int EN_W       = 2,
  parameter int INTEG_BITS = 11,
  parameter int ERR_W      = 8,
  parameter int STAT_W     = 8,
  parameter int TBE_POS    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EN_W-1:0]   xmit_enable,
  input  logic              sample_stb,
  input  logic              rx_bit,
  input  logic              tx_data,
  output logic              bus_ready,
  output logic              drv_oe,
  output logic              tx_line,
  output logic              rx_accept,
  output logic [1:0]        err_mode,
  output logic [ERR_W-1:0]  tx_err_cnt,
  output logic [ERR_W-1:0]  rx_err_cnt,
  output logic [STAT_W-1:0] status_word
);

  localparam int CW = $clog2(INTEG_BITS + 1);

  logic          any_en;
  logic          ctr_clear;
  logic          ctr_step;
  logic          run_hit;
  logic [CW-1:0] run_cnt;
  logic          ready_q;

  can_integ_enable_track #(.EN_W(EN_W)) u_en (
    .en_bits (xmit_enable),
    .any_en  (any_en)
  );

  can_integ_run_counter #(.LIMIT(INTEG_BITS)) u_run (
    .clk   (clk),
    .rst   (rst),
    .clear (ctr_clear),
    .step  (ctr_step),
    .count (run_cnt),
    .hit   (run_hit)
  );

  can_integ_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .any_en    (any_en),
    .strobe    (sample_stb),
    .rx_bit    (rx_bit),
    .run_hit   (run_hit),
    .ctr_clear (ctr_clear),
    .ctr_step  (ctr_step),
    .ready_q   (ready_q)
  );

  can_integ_reset_image #(
    .ERR_W   (ERR_W),
    .STAT_W  (STAT_W),
    .TBE_POS (TBE_POS)
  ) u_img (
    .clk    (clk),
    .rst    (rst),
    .mode_q (err_mode),
    .tec_q  (tx_err_cnt),
    .rec_q  (rx_err_cnt),
    .stat_q (status_word)
  );

  assign bus_ready = ready_q;
  assign drv_oe    = ready_q;
  assign tx_line   = ready_q ? tx_data : 1'b1;
  assign rx_accept = ready_q & sample_stb;

  // R3
  open_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ready) |-> $past(sample_stb && rx_bit && (|xmit_enable)));

  // R4
  dom_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && !rx_bit && !bus_ready) |=> (run_cnt == '0));

  // R6
  drop_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_ready && !(|xmit_enable)) |=> !bus_ready);

  // R8
  pin_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !drv_oe |-> (tx_line == 1'b1));

endmodule

// File: tb/can_integ_gate_test.sv
module can_integ_gate_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] xmit_enable = 2'b00;
  logic       sample_stb = 1'b0;
  logic       rx_bit = 1'b1;
  logic       tx_data = 1'b1;
  logic       bus_ready, drv_oe, tx_line, rx_accept;
  logic [1:0] err_mode;
  logic [7:0] tx_err_cnt, rx_err_cnt, status_word;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  can_integ_gate uut (
    .clk(clk), .rst(rst), .xmit_enable(xmit_enable), .sample_stb(sample_stb),
    .rx_bit(rx_bit), .tx_data(tx_data), .bus_ready(bus_ready), .drv_oe(drv_oe),
    .tx_line(tx_line), .rx_accept(rx_accept), .err_mode(err_mode),
    .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt), .status_word(status_word)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; xmit_enable = 2'b00; sample_stb = 1'b0; rx_bit = 1'b1; tx_data = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_en(input logic [1:0] v);
    @(negedge clk);
    xmit_enable = v;
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    sample_stb = 1'b1; rx_bit = b;
    @(negedge clk);
    sample_stb = 1'b0; rx_bit = 1'b1;
  endtask

  task automatic send_run(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic t_reset();
    do_reset();
    check(bus_ready == 0 && drv_oe == 0 && tx_line == 1 && rx_accept == 0,
          "R1 gate outputs", {bus_ready, drv_oe, tx_line, rx_accept}, 4'b0010);
    check(err_mode == 2'b00, "R1 err_mode", err_mode, 0);
    check(tx_err_cnt == 0 && rx_err_cnt == 0, "R1 counters", tx_err_cnt + rx_err_cnt, 0);
    check(status_word == 8'h04, "R1 status", status_word, 8'h04);
  endtask

  task automatic t_no_enable();
    do_reset();
    send_run(20);
    check(bus_ready == 0, "R2 disabled no ready", bus_ready, 0);
  endtask

  task automatic t_eleven();
    do_reset();
    set_en(2'b01);
    send_run(10);
    check(bus_ready == 0, "R3 ten not enough", bus_ready, 0);
    tx_data = 1'b0;
    #1;
    check(tx_line == 1, "R8 tx held recessive", tx_line, 1);
    send_bit(1'b1);
    check(bus_ready == 1, "R3 eleventh opens", bus_ready, 1);
    check(drv_oe == 1, "R8 drv_oe follows", drv_oe, 1);
    check(tx_line == 0, "R8 tx passes data", tx_line, 0);
    tx_data = 1'b1;
    sample_stb = 1'b1;
    #1;
    check(rx_accept == 1, "R9 strobe forwarded", rx_accept, 1);
    sample_stb = 1'b0;
    send_bit(1'b0);
    send_bit(1'b0);
    check(bus_ready == 1, "R10 traffic keeps open", bus_ready, 1);
  endtask

  task automatic t_rx_gate_closed();
    do_reset();
    set_en(2'b10);
    @(negedge clk);
    sample_stb = 1'b1;
    #1;
    check(rx_accept == 0, "R9 strobe blocked", rx_accept, 0);
    sample_stb = 1'b0;
  endtask

  task automatic t_dominant_restart();
    do_reset();
    set_en(2'b01);
    send_run(7);
    send_bit(1'b0);
    send_run(10);
    check(bus_ready == 0, "R4 ten after dominant", bus_ready, 0);
    send_bit(1'b1);
    check(bus_ready == 1, "R4 eleven after dominant", bus_ready, 1);
  endtask

  task automatic t_either_bit();
    do_reset();
    set_en(2'b10);
    send_run(11);
    check(bus_ready == 1, "R5 bit1 alone", bus_ready, 1);
  endtask

  task automatic t_drop();
    do_reset();
    set_en(2'b11);
    send_run(11);
    check(bus_ready == 1, "R6 open before drop", bus_ready, 1);
    set_en(2'b00);
    check(bus_ready == 0, "R6 drop closes", bus_ready, 0);
    set_en(2'b01);
    send_run(10);
    check(bus_ready == 0, "R6 re-enable needs run", bus_ready, 0);
    send_bit(1'b1);
    check(bus_ready == 1, "R6 reopen", bus_ready, 1);
  endtask

  task automatic t_strobe_only();
    do_reset();
    set_en(2'b01);
    @(negedge clk);
    rx_bit = 1'b1;
    repeat (15) @(negedge clk);
    check(bus_ready == 0, "R7 no strobe no count", bus_ready, 0);
    send_run(10);
    @(negedge clk);
    rx_bit = 1'b0;
    repeat (3) @(negedge clk);
    rx_bit = 1'b1;
    send_bit(1'b1);
    check(bus_ready == 1, "R7 unstrobed dominant ignored", bus_ready, 1);
    check(tx_err_cnt == 0 && rx_err_cnt == 0 && status_word == 8'h04 && err_mode == 0,
          "R11 image held", status_word, 8'h04);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_no_enable();
    t_eleven();
    t_rx_gate_closed();
    t_dominant_restart();
    t_either_bit();
    t_drop();
    t_strobe_only();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule